// File: doc/BRIEF.md
# Debug-Aware Low-Power Mode Controller

This block sits between the core's low-power mode requests and the power controller. It takes a requested mode (normal run, low-power run, low-power wait, stop, low-power stop, retained-state stop, or power-off stop) and decides which mode the chip enters. That decision depends on where the chip is now and on whether an external debugger is attached. When debug is enabled, low-power stop would cut power to the debug logic, so the block grants plain stop instead. It then raises a status flag that the debugger can read, marking the substituted stop.

For each debug sub-block (debug port, bus access port, instrumentation trace, trace port, watchpoint unit) the block drives a two-bit power indication: full function, retained, or off. The power-off stop mode removes power from the debug domain, and the block holds that domain in reset while the chip is in this mode. The debugger can set a hold bit, which is kept in an always-on register. If that bit is set, waking from power-off stop keeps the system in reset until the debugger clears the bit, which gives the debugger time to set up its logic again first.

The controller is a state machine with eight states: S_RUN, S_LPRUN, S_LPWAIT, S_STOP, S_LPSTOP, S_RETAIN, S_OFF and S_HOLD.

Transitions:
- From S_RUN, a request moves the machine to S_LPRUN, S_STOP, S_LPSTOP (or to S_STOP when debug is enabled), S_RETAIN or S_OFF.
- From S_LPRUN, a request moves it to S_RUN, S_LPWAIT or S_LPSTOP (again S_STOP when debug is enabled).
- On a wake pulse:
  - S_LPWAIT returns to S_LPRUN.
  - S_STOP and S_LPSTOP return to the run state they were entered from.
  - S_RETAIN returns to S_RUN.
  - S_OFF goes to S_HOLD if the hold bit is set, otherwise to S_RUN.
- S_HOLD leaves for S_RUN once the hold bit reads clear.

Top module: `lpm_dbg_ctrl`

## Requirements
- R1: After reset the effective mode is run (code 0), the substitution flag is 0, every sub-block reports full function (code 0), and neither reset output is asserted. Mode codes: run 0, low-power run 1, low-power wait 2, stop 3, low-power stop 4, retained stop 5, power-off stop 6.
- R2: With debug disabled, a legal request is granted unchanged; low-power stop requested from run or low-power run is entered as low-power stop (4), and the flag stays 0.
- R3: With debug enabled, a low-power stop request from run is entered as stop (3) on the next clock, and the flag is set to 1.
- R4: With debug enabled, a low-power stop request from low-power run is entered as stop with the flag set. A wake returns to low-power run with the flag still set. The flag clears when the machine next enters run.
- R5: Per-sub-block power code (2 bits each, sub-block 0 in the low bits) is full (0) in run, low-power run, low-power wait, stop and the held state; retained (1) in retained stop; off (2) in low-power stop and power-off stop.
- R6: Illegal requests leave the mode unchanged. These are: low-power wait from run; retained or power-off stop from low-power run; any request while in a stop or wait mode or in the held state; and codes 0 or 7 where they do not apply.
- R7: A wake pulse returns low-power wait to low-power run, stop and low-power stop to the run state they were entered from, and retained stop to run. A wake is ignored in run and low-power run.
- R8: While in power-off stop, the debug-domain reset output is 1 and all sub-blocks report off. A wake with the hold bit clear returns to run with the debug reset released.
- R9: A wake from power-off stop with the hold bit set enters the held state. In that state the system-reset-hold output is 1, the mode reads run, the debug reset is 0, and requests are ignored. The machine returns to run on the clock after a write that clears the hold bit.
- R10: The hold bit survives power-off stop, and writes to it are ignored while the debug-domain reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 3 | Requested mode code |
| wake | input | 1 | Single-cycle wakeup pulse |
| dbg_en | input | 1 | Debugger attached and enabled |
| hold_wr | input | 1 | Write strobe for the hold bit |
| hold_val | input | 1 | Value written to the hold bit |
| eff_mode | output | 3 | Mode actually in effect |
| pseudo_flag | output | 1 | Low-power stop was replaced by stop |
| dbg_pwr | output | 2*NUM_DBG_BLK | Power indication per debug sub-block |
| dbg_rst | output | 1 | Debug-domain reset |
| sys_rst_hold | output | 1 | System held in reset after power-off wake |

## Verification
The bench drives the substitution along both paths, direct from run and through low-power run, and checks that the flag stays set across the wake back to low-power run. A design that cleared the flag early, or that granted low-power stop while debug was enabled, would miscompare there. It also sends requests that are illegal in each state; a design that obeyed them would leave the expected mode. For the hold sequence, the bench writes the hold bit while the debug domain is in reset, wakes into the held state, and times the release. A design that reset the hold bit along with the debug logic, accepted the write during power-off, or released one cycle early or late would give the wrong reset outputs.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int MODE_W = 3;
    localparam int PWR_W  = 2;

    typedef enum logic [MODE_W-1:0] {
        M_RUN     = 3'd0,
        M_LPRUN   = 3'd1,
        M_LPWAIT  = 3'd2,
        M_STOP    = 3'd3,
        M_LPSTOP  = 3'd4,
        M_RETAIN  = 3'd5,
        M_DEEPOFF = 3'd6
    } mode_t;

    typedef enum logic [PWR_W-1:0] {
        PWR_FULL = 2'd0,
        PWR_KEEP = 2'd1,
        PWR_OFF  = 2'd2
    } pwr_t;

    typedef enum logic [2:0] {
        S_RUN, S_LPRUN, S_LPWAIT, S_STOP, S_LPSTOP, S_RETAIN, S_OFF, S_HOLD
    } lpm_state_t;

endpackage

// File: rtl/lpm_hold_reg.sv
module lpm_hold_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic val,
    input  logic dom_rst,
    output logic hold_q
);
    // Always-on storage: only power-on reset clears it, never the debug reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hold_q <= 1'b0;
        else if (wr && !dom_rst)
            hold_q <= val;
    end
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
    import lpm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    input  mode_t  req_mode,
    input  logic   wake,
    input  logic   dbg_en,
    input  logic   hold_q,
    output mode_t  eff_mode,
    output pwr_t   pwr_code,
    output logic   dbg_rst,
    output logic   sys_rst_hold,
    output logic   pseudo_flag
);
    lpm_state_t st, nxt;
    logic       subst;
    logic       ret_lp;

    // Next-state decision
    always_comb begin
        nxt   = st;
        subst = 1'b0;
        unique case (st)
            S_RUN: begin
                if (req_valid) begin
                    case (req_mode)
                        M_LPRUN:   nxt = S_LPRUN;
                        M_STOP:    nxt = S_STOP;
                        M_LPSTOP: begin
                            nxt   = dbg_en ? S_STOP : S_LPSTOP;
                            subst = dbg_en;
                        end
                        M_RETAIN:  nxt = S_RETAIN;
                        M_DEEPOFF: nxt = S_OFF;
                        default:   nxt = st;
                    endcase
                end
            end
            S_LPRUN: begin
                if (req_valid) begin
                    case (req_mode)
                        M_RUN:    nxt = S_RUN;
                        M_LPWAIT: nxt = S_LPWAIT;
                        M_LPSTOP: begin
                            nxt   = dbg_en ? S_STOP : S_LPSTOP;
                            subst = dbg_en;
                        end
                        default:  nxt = st;
                    endcase
                end
            end
            S_LPWAIT: if (wake) nxt = S_LPRUN;
            S_STOP, S_LPSTOP: if (wake) nxt = ret_lp ? S_LPRUN : S_RUN;
            S_RETAIN: if (wake) nxt = S_RUN;
            S_OFF:    if (wake) nxt = hold_q ? S_HOLD : S_RUN;
            S_HOLD:   if (!hold_q) nxt = S_RUN;
        endcase
    end

    // State register with return-path and substitution flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st          <= S_RUN;
            ret_lp      <= 1'b0;
            pseudo_flag <= 1'b0;
        end else begin
            st <= nxt;
            if (nxt != st && (nxt == S_STOP || nxt == S_LPSTOP))
                ret_lp <= (st == S_LPRUN);
            if (subst)
                pseudo_flag <= 1'b1;
            else if (nxt == S_RUN)
                pseudo_flag <= 1'b0;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        eff_mode     = M_RUN;
        pwr_code     = PWR_FULL;
        dbg_rst      = 1'b0;
        sys_rst_hold = 1'b0;
        unique case (st)
            S_RUN:    eff_mode = M_RUN;
            S_LPRUN:  eff_mode = M_LPRUN;
            S_LPWAIT: eff_mode = M_LPWAIT;
            S_STOP:   eff_mode = M_STOP;
            S_LPSTOP: begin
                eff_mode = M_LPSTOP;
                pwr_code = PWR_OFF;
            end
            S_RETAIN: begin
                eff_mode = M_RETAIN;
                pwr_code = PWR_KEEP;
            end
            S_OFF: begin
                eff_mode = M_DEEPOFF;
                pwr_code = PWR_OFF;
                dbg_rst  = 1'b1;
            end
            S_HOLD: begin
                eff_mode     = M_RUN;
                sys_rst_hold = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/lpm_pwr_fanout.sv
module lpm_pwr_fanout
    import lpm_pkg::*;
#(
    parameter int NUM_DBG_BLK = 5
) (
    input  pwr_t                          code,
    output logic [PWR_W*NUM_DBG_BLK-1:0]  blk_pwr
);
    for (genvar g = 0; g < NUM_DBG_BLK; g++) begin : g_blk
        assign blk_pwr[g*PWR_W +: PWR_W] = code;
    end
endmodule

// File: rtl/lpm_dbg_ctrl.sv
module lpm_dbg_ctrl
    import lpm_pkg::*;
#(
    parameter int NUM_DBG_BLK = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [2:0]                    req_mode,
    input  logic                          wake,
    input  logic                          dbg_en,
    input  logic                          hold_wr,
    input  logic                          hold_val,
    output logic [2:0]                    eff_mode,
    output logic                          pseudo_flag,
    output logic [2*NUM_DBG_BLK-1:0]      dbg_pwr,
    output logic                          dbg_rst,
    output logic                          sys_rst_hold
);
    logic  hold_q;
    mode_t mode_s;
    pwr_t  code_s;

    lpm_hold_reg u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (hold_wr),
        .val     (hold_val),
        .dom_rst (dbg_rst),
        .hold_q  (hold_q)
    );

    lpm_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_mode     (mode_t'(req_mode)),
        .wake         (wake),
        .dbg_en       (dbg_en),
        .hold_q       (hold_q),
        .eff_mode     (mode_s),
        .pwr_code     (code_s),
        .dbg_rst      (dbg_rst),
        .sys_rst_hold (sys_rst_hold),
        .pseudo_flag  (pseudo_flag)
    );

    lpm_pwr_fanout #(.NUM_DBG_BLK(NUM_DBG_BLK)) u_fan (
        .code    (code_s),
        .blk_pwr (dbg_pwr)
    );

    assign eff_mode = mode_s;
endmodule

// File: rtl/lpm_dbg_ctrl_chk.sv
module lpm_dbg_ctrl_chk #(
    parameter int NUM_DBG_BLK = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic [2:0]               req_mode,
    input logic                     dbg_en,
    input logic [2:0]               eff_mode,
    input logic                     pseudo_flag,
    input logic [2*NUM_DBG_BLK-1:0] dbg_pwr,
    input logic                     dbg_rst,
    input logic                     sys_rst_hold
);
    localparam logic [2*NUM_DBG_BLK-1:0] ALL_OFF  = {NUM_DBG_BLK{2'd2}};
    localparam logic [2*NUM_DBG_BLK-1:0] ALL_KEEP = {NUM_DBG_BLK{2'd1}};

    // R2
    nodbg_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_en && req_valid && req_mode == 3'd4 && eff_mode == 3'd0 && !sys_rst_hold)
        |=> eff_mode == 3'd4);

    // R3
    subst_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_en && req_valid && req_mode == 3'd4 && eff_mode == 3'd0 && !sys_rst_hold)
        |=> (eff_mode == 3'd3 && pseudo_flag));

    // R4
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_mode == 3'd0) |-> !pseudo_flag);

    // R5
    lpstop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_mode == 3'd4) |-> dbg_pwr == ALL_OFF);

    // R5
    retain_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_mode == 3'd5) |-> dbg_pwr == ALL_KEEP);

    // R6
    illegal_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 3'd2 && eff_mode == 3'd0 && !sys_rst_hold)
        |=> eff_mode == 3'd0);

    // R8
    dom_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_rst |-> (eff_mode == 3'd6 && dbg_pwr == ALL_OFF));

    // R9
    hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_hold) |-> $past(dbg_rst));
endmodule

bind lpm_dbg_ctrl lpm_dbg_ctrl_chk #(.NUM_DBG_BLK(NUM_DBG_BLK)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_mode     (req_mode),
    .dbg_en       (dbg_en),
    .eff_mode     (eff_mode),
    .pseudo_flag  (pseudo_flag),
    .dbg_pwr      (dbg_pwr),
    .dbg_rst      (dbg_rst),
    .sys_rst_hold (sys_rst_hold)
);

// File: tb/test_lpm_dbg_ctrl.sv
`timescale 1ns/1ps
module test_lpm_dbg_ctrl;
    localparam int NB = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_mode = 3'd0;
    logic wake = 1'b0;
    logic dbg_en = 1'b0;
    logic hold_wr = 1'b0;
    logic hold_val = 1'b0;
    logic [2:0] eff_mode;
    logic pseudo_flag;
    logic [2*NB-1:0] dbg_pwr;
    logic dbg_rst;
    logic sys_rst_hold;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [2:0] mode;
        logic       flag;
        logic [1:0] pwr;
        logic       drst;
        logic       hold;
        string      tag;
    } exp_t;

    exp_t q[$];

    always #4 clk = ~clk;

    lpm_dbg_ctrl #(.NUM_DBG_BLK(NB)) i_lpm_dbg_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .wake(wake), .dbg_en(dbg_en), .hold_wr(hold_wr), .hold_val(hold_val),
        .eff_mode(eff_mode), .pseudo_flag(pseudo_flag), .dbg_pwr(dbg_pwr),
        .dbg_rst(dbg_rst), .sys_rst_hold(sys_rst_hold)
    );

    function automatic logic [2*NB-1:0] rep(input logic [1:0] c);
        logic [2*NB-1:0] v;
        for (int i = 0; i < NB; i++) v[i*2 +: 2] = c;
        return v;
    endfunction

    task automatic compare(input exp_t e);
        n_chk++;
        if (eff_mode !== e.mode || pseudo_flag !== e.flag || dbg_pwr !== rep(e.pwr) ||
            dbg_rst !== e.drst || sys_rst_hold !== e.hold) begin
            n_bad++;
            $display("FAIL %s: got mode=%0d flag=%0b pwr=%h drst=%0b hold=%0b exp mode=%0d flag=%0b pwr=%h drst=%0b hold=%0b",
                     e.tag, eff_mode, pseudo_flag, dbg_pwr, dbg_rst, sys_rst_hold,
                     e.mode, e.flag, rep(e.pwr), e.drst, e.hold);
        end
    endtask

    // Monitor: after each active edge, compare against the oldest expectation
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) compare(q.pop_front());
    end

    // Driver: apply one cycle of stimulus and queue the expected result
    task automatic step(input logic v, input logic [2:0] m, input logic w,
                        input logic de, input logic hw, input logic hv,
                        input logic [2:0] em, input logic ef, input logic [1:0] ep,
                        input logic edr, input logic eh, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = v; req_mode = m; wake = w; dbg_en = de;
        hold_wr = hw; hold_val = hv;
        e.mode = em; e.flag = ef; e.pwr = ep; e.drst = edr; e.hold = eh; e.tag = tag;
        q.push_back(e);
    endtask

    initial begin
        exp_t r;
        repeat (2) @(negedge clk);
        r.mode = 3'd0; r.flag = 1'b0; r.pwr = 2'd0; r.drst = 1'b0; r.hold = 1'b0;
        r.tag = "R1 in reset";
        compare(r);
        rst_n = 1'b1;
        //   v  mode  w  dbg hw hv | mode flag pwr drst hold
        step(0, 3'd0, 0, 0, 0, 0,  3'd0, 0, 2'd0, 0, 0, "R1 idle after reset");
        step(1, 3'd4, 0, 0, 0, 0,  3'd4, 0, 2'd2, 0, 0, "R2 lpstop granted, no debug");
        step(0, 3'd0, 1, 0, 0, 0,  3'd0, 0, 2'd0, 0, 0, "R7 lpstop wake to run");
        step(1, 3'd2, 0, 0, 0, 0,  3'd0, 0, 2'd0, 0, 0, "R6 wait from run ignored");
        step(1, 3'd4, 0, 1, 0, 0,  3'd3, 1, 2'd0, 0, 0, "R3 lpstop becomes stop");
        step(1, 3'd0, 0, 1, 0, 0,  3'd3, 1, 2'd0, 0, 0, "R6 request in stop ignored");
        step(0, 3'd0, 1, 1, 0, 0,  3'd0, 0, 2'd0, 0, 0, "R4 flag clears on run");
        step(1, 3'd1, 0, 1, 0, 0,  3'd1, 0, 2'd0, 0, 0, "R5 lprun full");
        step(0, 3'd0, 1, 1, 0, 0,  3'd1, 0, 2'd0, 0, 0, "R7 wake in lprun ignored");
        step(1, 3'd5, 0, 1, 0, 0,  3'd1, 0, 2'd0, 0, 0, "R6 retain from lprun ignored");
        step(1, 3'd2, 0, 1, 0, 0,  3'd2, 0, 2'd0, 0, 0, "R5 lpwait full");
        step(0, 3'd0, 1, 1, 0, 0,  3'd1, 0, 2'd0, 0, 0, "R7 lpwait wake to lprun");
        step(1, 3'd4, 0, 1, 0, 0,  3'd3, 1, 2'd0, 0, 0, "R4 lprun path becomes stop");
        step(0, 3'd0, 1, 1, 0, 0,  3'd1, 1, 2'd0, 0, 0, "R4 wake to lprun keeps flag");
        step(1, 3'd0, 0, 1, 0, 0,  3'd0, 0, 2'd0, 0, 0, "R4 run clears flag");
        step(1, 3'd1, 0, 0, 0, 0,  3'd1, 0, 2'd0, 0, 0, "R2 lprun no debug");
        step(1, 3'd4, 0, 0, 0, 0,  3'd4, 0, 2'd2, 0, 0, "R2 lpstop from lprun granted");
        step(0, 3'd0, 1, 0, 0, 0,  3'd1, 0, 2'd0, 0, 0, "R7 lpstop wake to origin lprun");
        step(1, 3'd0, 0, 0, 0, 0,  3'd0, 0, 2'd0, 0, 0, "R2 back to run");
        step(1, 3'd3, 0, 0, 0, 0,  3'd3, 0, 2'd0, 0, 0, "R5 stop full");
        step(0, 3'd0, 1, 0, 0, 0,  3'd0, 0, 2'd0, 0, 0, "R7 stop wake to run");
        step(1, 3'd5, 0, 0, 0, 0,  3'd5, 0, 2'd1, 0, 0, "R5 retain kept");
        step(0, 3'd0, 1, 0, 0, 0,  3'd0, 0, 2'd0, 0, 0, "R7 retain wake to run");
        step(1, 3'd6, 0, 0, 0, 0,  3'd6, 0, 2'd2, 1, 0, "R8 power-off stop");
        step(0, 3'd0, 0, 0, 0, 0,  3'd6, 0, 2'd2, 1, 0, "R8 stays off");
        step(0, 3'd0, 1, 0, 0, 0,  3'd0, 0, 2'd0, 0, 0, "R8 wake no hold");
        step(0, 3'd0, 0, 1, 1, 1,  3'd0, 0, 2'd0, 0, 0, "R10 set hold bit");
        step(1, 3'd6, 0, 1, 0, 0,  3'd6, 0, 2'd2, 1, 0, "R8 off with hold");
        step(0, 3'd0, 0, 1, 1, 0,  3'd6, 0, 2'd2, 1, 0, "R10 write during off");
        step(0, 3'd0, 1, 1, 0, 0,  3'd0, 0, 2'd0, 0, 1, "R10 hold survived, R9 held");
        step(1, 3'd1, 0, 1, 0, 0,  3'd0, 0, 2'd0, 0, 1, "R9 request in hold ignored");
        step(0, 3'd0, 0, 1, 1, 0,  3'd0, 0, 2'd0, 0, 1, "R9 clear write, still held");
        step(0, 3'd0, 0, 1, 0, 0,  3'd0, 0, 2'd0, 0, 0, "R9 released");
        step(1, 3'd6, 0, 1, 0, 0,  3'd6, 0, 2'd2, 1, 0, "R8 off again");
        step(0, 3'd0, 1, 1, 0, 0,  3'd0, 0, 2'd0, 0, 0, "R10 cleared bit stays clear");
        step(0, 3'd0, 0, 0, 0, 0,  3'd0, 0, 2'd0, 0, 0, "R1 idle end");
        wait (q.size() == 0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got running exp finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule